// File: doc/BRIEF.md
# Pipelined Two-Stage Pixel Code Array

This block models the digital code memory of a coded-exposure pixel array. Every pixel keeps a one-bit code in two storage stages. The first stage (the staging bit) is written one row at a time from a shared column code bus. The second stage (the applied bit) is copied from the staging bit in every pixel at once, when a single array-wide transfer strobe is given. The applied bit steers the pixel's photo-generated charge to one of two storage taps. It does this by enabling exactly one of two transfer gates, and only while the exposure enable is high.

In use, the controller streams the codes for the next subframe into the staging bits row by row while the current subframe's codes stay applied. It then lowers exposure and pulses the transfer strobe, and every pixel switches to its new code in the same cycle. Charge transfer, photodiodes and readout are outside the block. It produces only the gate enables.

Top module: `pcode_array`

## Requirements
- R1: Synchronous active-high reset clears the staging and applied bits of every pixel to 0. After reset, with exposure high and no transfer, every pixel enables its tap-1 gate.
- R2: At a clock edge where `row_load[r]` is high, the staging bits of row r take `col_code`, with bit c going to column c.
- R3: A row load does not change any applied bit. The gate outputs keep their values across row loads until the next transfer.
- R4: At a clock edge where `xfer` is high, every pixel's applied bit takes that pixel's staging bit. The gate outputs reflect the new codes from that edge on.
- R5: An applied code of 0 enables only `tg1_en` of that pixel, and an applied code of 1 enables only `tg2_en`. Pixel (r,c) is bit r*COLS+c of both output vectors.
- R6: While `expose` is low, both gate enables of every pixel are low, whatever the stored codes.
- R7: When a row load and a transfer fall on the same edge, the applied bits take the staging values from before that edge. The newly loaded row becomes applied only at a later transfer.
- R8: Transfers happen only while `expose` is low. A transfer with exposure high is flagged. Every pixel switches to its new code in the same cycle.
- R9: At most one row-load enable is high in any cycle. A row load leaves the staging bits of all other rows unchanged.
- R10: Several loads of the same row before a transfer leave the last loaded value in that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| col_code | input | COLS | Column code bus for the row being loaded |
| row_load | input | ROWS | One-hot row write enable for the staging bits |
| xfer | input | 1 | Array-wide copy of staging bits into applied bits |
| expose | input | 1 | Exposure enable that gates both transfer gates |
| tg1_en | output | ROWS*COLS | Tap-1 transfer-gate enable per pixel, index r*COLS+c |
| tg2_en | output | ROWS*COLS | Tap-2 transfer-gate enable per pixel, index r*COLS+c |

## Verification
Assertions check on every cycle that:
- a transfer never coincides with exposure;
- row loads are one-hot;
- no pixel enables both gates;
- gates are off without exposure;
- applied codes hold when there is no transfer;
- a transfer copies the pre-edge staging plane.

Only the bench's scenarios can show the following, where a cycle-by-cycle model compares the full gate vectors:
- which row and column a loaded code lands in;
- that untouched rows keep their codes;
- that the last of repeated loads wins;
- that a row loaded together with a transfer surfaces only at the following transfer.

// File: rtl/pcode_pkg.sv
package pcode_pkg;

    // Meaning of a stored code bit
    typedef enum logic {
        TAP_ONE = 1'b0,
        TAP_TWO = 1'b1
    } tap_sel_e;

    // Pair of gate enables for one pixel
    typedef struct packed {
        logic tg1;
        logic tg2;
    } gate_pair_t;

    // Gate enables for one applied code under the exposure enable
    function automatic gate_pair_t gate_of(input logic code, input logic expose);
        gate_pair_t g;
        g.tg1 = expose && (tap_sel_e'(code) == TAP_ONE);
        g.tg2 = expose && (tap_sel_e'(code) == TAP_TWO);
        return g;
    endfunction

endpackage

// File: rtl/pc_load_bank.sv
module pc_load_bank #(
    parameter int ROWS = 8,
    parameter int COLS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [COLS-1:0]        col_code,
    input  logic [ROWS-1:0]        row_load,
    output logic [ROWS*COLS-1:0]   staged
);

    // One row of staging bits per generate iteration
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (row_load[r]) begin
                row_q <= col_code;
            end
        end

        assign staged[r*COLS +: COLS] = row_q;
    end

endmodule

// File: rtl/pc_apply_bank.sv
module pc_apply_bank #(
    parameter int NPIX = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            xfer,
    input  logic [NPIX-1:0] staged,
    output logic [NPIX-1:0] applied
);

    // Array-wide copy; a same-edge row load is not yet visible in staged
    always_ff @(posedge clk) begin
        if (rst) begin
            applied <= '0;
        end else if (xfer) begin
            applied <= staged;
        end
    end

endmodule

// File: rtl/pc_gate_drive.sv
module pc_gate_drive
    import pcode_pkg::*;
#(
    parameter int NPIX = 128
) (
    input  logic            expose,
    input  logic [NPIX-1:0] applied,
    output logic [NPIX-1:0] tg1_en,
    output logic [NPIX-1:0] tg2_en
);

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        gate_pair_t gp;
        always_comb gp = gate_of(applied[p], expose);
        assign tg1_en[p] = gp.tg1;
        assign tg2_en[p] = gp.tg2;
    end

endmodule

// File: rtl/pcode_array.sv
module pcode_array
    import pcode_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [COLS-1:0]      col_code,
    input  logic [ROWS-1:0]      row_load,
    input  logic                 xfer,
    input  logic                 expose,
    output logic [ROWS*COLS-1:0] tg1_en,
    output logic [ROWS*COLS-1:0] tg2_en
);

    localparam int NPIX = ROWS * COLS;

    logic [NPIX-1:0] staged;
    logic [NPIX-1:0] applied;

    pc_load_bank #(.ROWS(ROWS), .COLS(COLS)) u_load (
        .clk      (clk),
        .rst      (rst),
        .col_code (col_code),
        .row_load (row_load),
        .staged   (staged)
    );

    pc_apply_bank #(.NPIX(NPIX)) u_apply (
        .clk     (clk),
        .rst     (rst),
        .xfer    (xfer),
        .staged  (staged),
        .applied (applied)
    );

    pc_gate_drive #(.NPIX(NPIX)) u_gate (
        .expose  (expose),
        .applied (applied),
        .tg1_en  (tg1_en),
        .tg2_en  (tg2_en)
    );

    // R8: transfer only while exposure is low
    assert_xfer_dark_R8: assert property (@(posedge clk) disable iff (rst)
        xfer |-> !expose);

    // R9: at most one row written per cycle
    assert_row_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_load));

    // R5: never both taps at once
    assert_one_tap_R5: assert property (@(posedge clk) disable iff (rst)
        (tg1_en & tg2_en) == '0);

    // R6: gates are off without exposure
    assert_dark_off_R6: assert property (@(posedge clk) disable iff (rst)
        !expose |-> (tg1_en == '0 && tg2_en == '0));

    // R3: applied codes hold without a transfer, whatever rows are loaded
    assert_hold_applied_R3: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(applied));

    // R4 / R7: a transfer copies the staging plane from before the edge
    assert_copy_old_R7: assert property (@(posedge clk) disable iff (rst)
        xfer |=> applied == $past(staged));

endmodule

// File: tb/pcode_array_bench.sv
`timescale 1ns/1ps
module pcode_array_bench;

    localparam int ROWS = 8;
    localparam int COLS = 16;
    localparam int NPIX = ROWS * COLS;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [COLS-1:0] col_code = '0;
    logic [ROWS-1:0] row_load = '0;
    logic            xfer = 1'b0;
    logic            expose = 1'b0;
    logic [NPIX-1:0] tg1_en;
    logic [NPIX-1:0] tg2_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state: staging and applied code per pixel
    bit m_stage [ROWS][COLS];
    bit m_apply [ROWS][COLS];

    always #4 clk = ~clk;

    pcode_array #(.ROWS(ROWS), .COLS(COLS)) u_pcode_array (
        .clk      (clk),
        .rst      (rst),
        .col_code (col_code),
        .row_load (row_load),
        .xfer     (xfer),
        .expose   (expose),
        .tg1_en   (tg1_en),
        .tg2_en   (tg2_en)
    );

    task automatic compare(input string tag);
        logic [NPIX-1:0] e1;
        logic [NPIX-1:0] e2;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                e1[r*COLS+c] = expose && !m_apply[r][c];
                e2[r*COLS+c] = expose &&  m_apply[r][c];
            end
        end
        checks++;
        if (tg1_en !== e1 || tg2_en !== e2) begin
            fails++;
            $display("FAIL %s: tg1=%h tg2=%h expected tg1=%h tg2=%h",
                     tag, tg1_en, tg2_en, e1, e2);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare after
    task automatic step(input logic [COLS-1:0] c, input logic [ROWS-1:0] rl,
                        input logic x, input logic e, input string tag);
        @(negedge clk);
        col_code = c; row_load = rl; xfer = x; expose = e;
        @(posedge clk);
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int k = 0; k < COLS; k++) begin
                    m_stage[r][k] = 1'b0; m_apply[r][k] = 1'b0;
                end
        end else begin
            if (x)
                for (int r = 0; r < ROWS; r++)
                    for (int k = 0; k < COLS; k++) m_apply[r][k] = m_stage[r][k];
            for (int r = 0; r < ROWS; r++)
                if (rl[r])
                    for (int k = 0; k < COLS; k++) m_stage[r][k] = c[k];
        end
        #1;
        compare(tag);
    endtask

    function automatic logic [COLS-1:0] pat(input int r, input int k);
        return COLS'((16'hA5C3 << r) ^ (16'h3C0F >> k) ^ (r * 16'h0911));
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            summary();
        end
    end

    initial begin
        // R1: reset clears everything
        rst = 1'b1;
        step('1, '0, 1'b0, 1'b0, "R1 reset dark");
        step('1, '0, 1'b0, 1'b1, "R1 reset exposed all tap1");
        @(negedge clk); rst = 1'b0;
        step('0, '0, 1'b0, 1'b1, "R1 after reset tap1");

        // R2/R3: load every row while exposed; outputs hold
        for (int r = 0; r < ROWS; r++)
            step(pat(r, 0), ROWS'(1) << r, 1'b0, 1'b1, "R3 load keeps applied");

        // R6: exposure low forces all gates off
        step('0, '0, 1'b0, 1'b0, "R6 dark before transfer");
        // R4: transfer with exposure low
        step('0, '0, 1'b1, 1'b0, "R4 transfer edge dark");
        // R2/R5/R8: new codes applied in every pixel at once
        step('0, '0, 1'b0, 1'b1, "R2 R5 R8 new codes applied");
        step('0, '0, 1'b0, 1'b0, "R6 dark with mixed codes");

        // R7: load and transfer on one edge
        step(16'hFFFF, ROWS'(1) << 2, 1'b0, 1'b0, "R7 preload row2");
        step(16'h0000, ROWS'(1) << 2, 1'b1, 1'b0, "R7 load with transfer");
        step('0, '0, 1'b0, 1'b1, "R7 old staging applied");
        step('0, '0, 1'b1, 1'b0, "R7 second transfer");
        step('0, '0, 1'b0, 1'b1, "R7 new row now applied");

        // R9: only the loaded row changes
        step(16'h5A5A, ROWS'(1) << 6, 1'b0, 1'b1, "R9 single row load");
        step('0, '0, 1'b1, 1'b0, "R9 transfer");
        step('0, '0, 1'b0, 1'b1, "R9 other rows unchanged");

        // R10: last of repeated loads wins
        step(16'h1234, ROWS'(1) << 5, 1'b0, 1'b1, "R10 first load");
        step(16'hBEEF, ROWS'(1) << 5, 1'b0, 1'b1, "R10 second load");
        step(16'h0F0F, ROWS'(1) << 5, 1'b0, 1'b1, "R10 third load");
        step('0, '0, 1'b1, 1'b0, "R10 transfer");
        step('0, '0, 1'b0, 1'b1, "R10 last value applied");

        // R5 boundary: all ones then all zeros
        for (int r = 0; r < ROWS; r++)
            step('1, ROWS'(1) << r, 1'b0, 1'b1, "R5 fill ones");
        step('0, '0, 1'b1, 1'b0, "R5 transfer ones");
        step('0, '0, 1'b0, 1'b1, "R5 all tap2");
        for (int r = 0; r < ROWS; r++)
            step('0, ROWS'(1) << r, 1'b0, 1'b1, "R3 fill zeros keeps tap2");
        step('0, '0, 1'b1, 1'b0, "R4 transfer zeros");
        step('0, '0, 1'b0, 1'b1, "R5 all tap1");

        // R4: varied pattern with a column sweep
        for (int r = 0; r < ROWS; r++)
            step(pat(r, 3) ^ COLS'(r), ROWS'(1) << r, 1'b0, 1'b0, "R2 dark load");
        step('0, '0, 1'b1, 1'b0, "R4 transfer varied");
        step('0, '0, 1'b0, 1'b1, "R4 varied applied");

        done = 1'b1;
        summary();
    end

endmodule